// File: doc/BRIEF.md
# Per-Frame Bounding Box Tracker

This block watches a raster scan of binarized pixels and finds the smallest axis-aligned rectangle that holds every foreground pixel of a frame. Each pixel arrives with its column and row coordinates, which count upward from 1 across the active area. A pixel-valid qualifier marks the active area, and single-cycle strobes mark the start and the end of each frame.

During a frame, four running registers hold the extremes found so far. Each frame-start strobe sets them to the opposite limits: the left edge takes the largest column and the right edge takes column 1, and the row edges start the same way. The visible outputs change only when the frame-end strobe arrives, when the running values are copied into them. A display that draws the rectangle therefore sees one fixed box for the whole of the following frame. A flag reports whether the last finished frame held any foreground pixel.

Top module: `bbox_tracker`

## Requirements
- R1: While reset is active and just after it is released, all four box outputs and `boxValid` read 0.
- R2: Only a pixel whose value equals 8'hFF counts as foreground. Any other value, 8'hFE for example, leaves the box unchanged.
- R3: For the foreground pixels of a frame, `xMin` reports the smallest column and `xMax` reports the largest column.
- R4: For the foreground pixels of a frame, `yMin` reports the smallest row and `yMax` reports the largest row.
- R5: The outputs change only on the clock edge that samples `frameEnd` high, and they hold their values through the whole next frame.
- R6: `frameStart` sets the running extremes back to the opposite limits, so the pixels of an earlier frame have no effect on the next box.
- R7: When a frame ends with no foreground pixel, `boxValid` reads 0 and the four box outputs keep the values they had before.
- R8: A foreground pixel in the same cycle as `frameStart` is compared against the reset limits and counts toward the new frame.
- R9: A foreground pixel in the same cycle as `frameEnd` is included in that frame's snapshot.
- R10: A pixel sampled while `pixValid` is low is ignored, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | High while the scan is inside the active area |
| pixVal | input | 8 | Binarized pixel value (8'hFF means foreground) |
| pixX | input | XW | Column coordinate, 1..COLS |
| pixY | input | YW | Row coordinate, 1..ROWS |
| frameStart | input | 1 | One-cycle strobe at frame start |
| frameEnd | input | 1 | One-cycle strobe at frame end |
| xMin | output | XW | Snapshot of the left edge |
| xMax | output | XW | Snapshot of the right edge |
| yMin | output | YW | Snapshot of the top edge |
| yMax | output | YW | Snapshot of the bottom edge |
| boxValid | output | 1 | The last frame held at least one foreground pixel |

## Verification
The bench places its distractors at the extreme corners: a pixel of 8'hFE at (1,1) and a qualified-off 8'hFF at (COLS,ROWS). A design with a loose value or qualifier test would stretch the box out to the corners. A single-pixel frame follows a wide frame. A design that did not reinitialize its extremes would report the old, wider box. An empty frame must clear the flag and keep the old box. A frame whose first and last pixels share a cycle with the start and end strobes must reach both corners, so a design that dropped either pixel would report a smaller box. In the middle of each frame the bench also checks that the outputs still show the previous snapshot, which catches a box that follows the scan.

// File: rtl/bbox_pkg.sv
package bbox_pkg;
  localparam logic [7:0] FG_CODE = 8'hFF;

  typedef struct packed {
    logic loadInit;   // start a new frame
    logic compareEn;  // qualified foreground pixel present
    logic snapshot;   // copy running extremes to outputs
  } bbox_ctl_t;
endpackage

// File: rtl/bbox_ctrl.sv
module bbox_ctrl
  import bbox_pkg::*;
(
  input  logic       pixValid,
  input  logic [7:0] pixVal,
  input  logic       frameStart,
  input  logic       frameEnd,
  output bbox_ctl_t  ctl
);
  always_comb begin
    ctl.loadInit  = frameStart;
    ctl.compareEn = pixValid && (pixVal == FG_CODE);
    ctl.snapshot  = frameEnd;
  end
endmodule

// File: rtl/bbox_axis.sv
module bbox_axis
  import bbox_pkg::*;
#(
  parameter int LIMIT = 320,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bbox_ctl_t    ctl,
  input  logic [W-1:0] coord,
  input  logic         takeSnap,
  output logic [W-1:0] outMin,
  output logic [W-1:0] outMax
);
  localparam logic [W-1:0] HI_LIM = W'(LIMIT);
  localparam logic [W-1:0] LO_LIM = W'(1);

  logic [W-1:0] runMin, runMax;
  logic [W-1:0] baseMin, baseMax;
  logic [W-1:0] nxtMin, nxtMax;

  always_comb begin
    baseMin = ctl.loadInit ? HI_LIM : runMin;
    baseMax = ctl.loadInit ? LO_LIM : runMax;
    nxtMin  = (ctl.compareEn && (coord < baseMin)) ? coord : baseMin;
    nxtMax  = (ctl.compareEn && (coord > baseMax)) ? coord : baseMax;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runMin <= HI_LIM;
      runMax <= LO_LIM;
      outMin <= '0;
      outMax <= '0;
    end else begin
      runMin <= nxtMin;
      runMax <= nxtMax;
      if (ctl.snapshot && takeSnap) begin
        outMin <= nxtMin;
        outMax <= nxtMax;
      end
    end
  end
endmodule

// File: rtl/bbox_datapath.sv
module bbox_datapath
  import bbox_pkg::*;
#(
  parameter int COLS = 320,
  parameter int ROWS = 240,
  parameter int XW   = $clog2(COLS + 1),
  parameter int YW   = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bbox_ctl_t     ctl,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  output logic [XW-1:0] xMin,
  output logic [XW-1:0] xMax,
  output logic [YW-1:0] yMin,
  output logic [YW-1:0] yMax,
  output logic          boxValid
);
  logic seen, nxtSeen;

  always_comb nxtSeen = (ctl.loadInit ? 1'b0 : seen) | ctl.compareEn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      boxValid <= 1'b0;
    end else begin
      seen <= nxtSeen;
      if (ctl.snapshot) boxValid <= nxtSeen;
    end
  end

  for (genvar a = 0; a < 2; a++) begin : gAxis
    if (a == 0) begin : gX
      bbox_axis #(.LIMIT(COLS), .W(XW)) uAxis (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .coord(pixX),
        .takeSnap(nxtSeen), .outMin(xMin), .outMax(xMax));
    end else begin : gY
      bbox_axis #(.LIMIT(ROWS), .W(YW)) uAxis (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .coord(pixY),
        .takeSnap(nxtSeen), .outMin(yMin), .outMax(yMax));
    end
  end
endmodule

// File: rtl/bbox_tracker.sv
module bbox_tracker
  import bbox_pkg::*;
#(
  parameter int COLS = 320,
  parameter int ROWS = 240,
  localparam int XW  = $clog2(COLS + 1),
  localparam int YW  = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pixValid,
  input  logic [7:0]    pixVal,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic          frameStart,
  input  logic          frameEnd,
  output logic [XW-1:0] xMin,
  output logic [XW-1:0] xMax,
  output logic [YW-1:0] yMin,
  output logic [YW-1:0] yMax,
  output logic          boxValid
);
  bbox_ctl_t ctl;

  bbox_ctrl uCtrl (
    .pixValid(pixValid), .pixVal(pixVal),
    .frameStart(frameStart), .frameEnd(frameEnd), .ctl(ctl));

  bbox_datapath #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pixX(pixX), .pixY(pixY),
    .xMin(xMin), .xMax(xMax), .yMin(yMin), .yMax(yMax),
    .boxValid(boxValid));
endmodule

// File: rtl/bbox_checker.sv
module bbox_checker #(
  parameter int COLS = 320,
  parameter int ROWS = 240,
  localparam int XW  = $clog2(COLS + 1),
  localparam int YW  = $clog2(ROWS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frameEnd,
  input logic [XW-1:0] xMin,
  input logic [XW-1:0] xMax,
  input logic [YW-1:0] yMin,
  input logic [YW-1:0] yMax,
  input logic          boxValid
);
  AST_HOLD_X: assert property (@(posedge clk) disable iff (!rst_n)
    !frameEnd |=> ($stable(xMin) && $stable(xMax))); // R5
  AST_HOLD_Y: assert property (@(posedge clk) disable iff (!rst_n)
    !frameEnd |=> ($stable(yMin) && $stable(yMax) && $stable(boxValid))); // R5
  AST_X_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    boxValid |-> (xMin <= xMax && xMin >= XW'(1) && xMax <= XW'(COLS))); // R3
  AST_Y_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    boxValid |-> (yMin <= yMax && yMin >= YW'(1) && yMax <= YW'(ROWS))); // R4
  AST_EMPTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boxValid) |-> ($stable(xMin) && $stable(xMax) && $stable(yMin) && $stable(yMax))); // R7
endmodule

bind bbox_tracker bbox_checker #(.COLS(COLS), .ROWS(ROWS)) uChk (
  .clk(clk), .rst_n(rst_n), .frameEnd(frameEnd),
  .xMin(xMin), .xMax(xMax), .yMin(yMin), .yMax(yMax), .boxValid(boxValid));

// File: tb/tb_bbox_tracker.sv
module tb_bbox_tracker;
  localparam int COLS = 320;
  localparam int ROWS = 240;
  localparam int XW = $clog2(COLS + 1);
  localparam int YW = $clog2(ROWS + 1);

  logic clk = 0, rst_n = 0, pixValid = 0, frameStart = 0, frameEnd = 0;
  logic [7:0] pixVal = 0;
  logic [XW-1:0] pixX = 0;
  logic [YW-1:0] pixY = 0;
  logic [XW-1:0] xMin, xMax;
  logic [YW-1:0] yMin, yMax;
  logic boxValid;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [XW-1:0] x; logic [YW-1:0] y; logic [7:0] v; logic ok;
  } px_t;
  typedef struct {
    logic [XW-1:0] x0, x1; logic [YW-1:0] y0, y1; logic vld;
  } box_t;

  px_t pq[$];
  box_t expQ[$];
  string tagQ[$];
  box_t prevExp = '{0, 0, 0, 0, 0};
  bit snapPending = 0;

  always #10 clk = ~clk;

  bbox_tracker #(.COLS(COLS), .ROWS(ROWS)) dut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkBox(string req, box_t e);
    chk({req, " xMin"}, xMin, e.x0);
    chk({req, " xMax"}, xMax, e.x1);
    chk({req, " yMin"}, yMin, e.y0);
    chk({req, " yMax"}, yMax, e.y1);
    chk({req, " boxValid"}, boxValid, e.vld);
  endtask

  task automatic addPx(int x, int y, logic [7:0] v, logic ok);
    px_t p; p.x = XW'(x); p.y = YW'(y); p.v = v; p.ok = ok;
    pq.push_back(p);
  endtask

  // driver: computes expected box, pushes it, then plays the frame
  task automatic sendFrame(bit mergeStart, bit mergeEnd, string tag);
    box_t e = '{XW'(COLS), XW'(1), YW'(ROWS), YW'(1), 1'b0};
    box_t held = prevExp;
    int n = pq.size();
    foreach (pq[i]) if (pq[i].ok && pq[i].v == 8'hFF) begin
      if (pq[i].x < e.x0) e.x0 = pq[i].x;
      if (pq[i].x > e.x1) e.x1 = pq[i].x;
      if (pq[i].y < e.y0) e.y0 = pq[i].y;
      if (pq[i].y > e.y1) e.y1 = pq[i].y;
      e.vld = 1;
    end
    if (!e.vld) begin e = prevExp; e.vld = 0; end
    expQ.push_back(e); tagQ.push_back(tag);
    prevExp = e;
    if (!mergeStart) begin
      @(negedge clk); frameStart = 1;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n / 2 && n > 1) chkBox("R5 mid-frame hold", held);
      frameStart = mergeStart && (i == 0);
      frameEnd = mergeEnd && (i == n - 1);
      pixValid = pq[i].ok; pixVal = pq[i].v; pixX = pq[i].x; pixY = pq[i].y;
    end
    if (!mergeEnd) begin
      @(negedge clk);
      frameStart = 0; pixValid = 0; pixVal = 0; frameEnd = 1;
    end
    @(negedge clk);
    frameStart = 0; frameEnd = 0; pixValid = 0; pixVal = 0;
    repeat (3) @(negedge clk);
    pq.delete();
  endtask

  // monitor: pops expected snapshot after each frame end
  always @(posedge clk) snapPending <= rst_n && frameEnd;
  always @(negedge clk) if (snapPending) begin
    if (expQ.size() == 0) chk("R5 unexpected snapshot", 1, 0);
    else chkBox(tagQ.pop_front(), expQ.pop_front());
  end

  initial begin
    repeat (4) @(negedge clk);
    chkBox("R1 during reset", '{0, 0, 0, 0, 0});
    rst_n = 1;
    @(negedge clk);
    chkBox("R1 after reset", '{0, 0, 0, 0, 0});

    // R2 R10 R3 R4: scattered pixels and corner distractors
    addPx(1, 1, 8'hFE, 1);
    addPx(10, 20, 8'hFF, 1);
    addPx(100, 5, 8'hFF, 1);
    addPx(COLS, ROWS, 8'hFF, 0);
    addPx(50, 200, 8'hFF, 1);
    addPx(3, 60, 8'hFF, 1);
    addPx(2, 2, 8'h7F, 1);
    sendFrame(0, 0, "R2 R10 R3 R4 scattered");

    // R6: single pixel after a wide frame
    addPx(160, 120, 8'hFF, 1);
    addPx(5, 5, 8'h00, 1);
    sendFrame(0, 0, "R6 reinit single");

    // R7: empty frame keeps box, clears flag
    addPx(1, 1, 8'hFE, 1);
    addPx(300, 200, 8'hFF, 0);
    sendFrame(0, 0, "R7 empty frame");

    // R8 R9: corner pixels on the strobe cycles
    addPx(1, 1, 8'hFF, 1);
    addPx(40, 40, 8'hFF, 1);
    addPx(COLS, ROWS, 8'hFF, 1);
    sendFrame(1, 1, "R8 R9 merged strobes");

    // R3 R4: new box after the merged frame, with a merged start only
    addPx(77, 9, 8'hFF, 1);
    addPx(12, 230, 8'hFF, 1);
    addPx(200, 100, 8'hFF, 1);
    sendFrame(1, 0, "R3 R4 R8 second box");

    repeat (3) @(negedge clk);
    chk("R5 pending snapshots", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule